// File: doc/BRIEF.md
# Receive Ring Buffer Pointer Manager

This block keeps the pointers of a circular receive buffer held in external 32-bit-wide memory. The host programs a start and an end offset, plus an output (read) pointer that software moves as it drains frames. The hardware owns the input (write) pointer. When the receive path announces a new frame, the block decides whether the frame fits before the end of the buffer. If it does not, the block first writes a zero marker word at the current input address, which tells the reader to go back to the start, and moves the input pointer to the start offset. It then checks that the frame cannot overrun unread data. If it fits, the block hands the receive path the word address to store it at. Otherwise it drops the frame and records an overflow.

Every pointer register shares one 12-bit base field, which is held in the start register and forms the upper address bits. The lower part is an 18-bit word offset. Three interrupt sources (frame stored, lack of space, overflow) are each gated by an enable and cleared by writing one. A control register carries the receiver enable, a level-held overflow clear and a level-held soft reset.

Top module: `rx_ring_ptr_mgr`

## Requirements
- R1: Register index 3 is start, 4 end, 5 input, 6 output. Each one reads as {base[11:0], offset[17:0], 2'b00}. The base is written only through the start register at bits 31..20, and the end, input and output registers show it as a read-only copy. The offset is written from bits 19..2, and bits 1..0 always read zero.
- R2: On an accepted frame start, if the input offset is at or beyond the end offset, or end minus input is below MAX_FRAME_WORDS, the block raises mem_req_o with mem_addr_o at the input address and mem_data_o zero. It holds the request until mem_ack_i. In the cycle after the ack, the input offset equals the start offset and the frame is accepted there.
- R3: When end minus input is at least MAX_FRAME_WORDS, the frame is accepted one cycle after frame_start_i, at the current input address, with no memory request.
- R4: Status bit 2 (lack of space) is 1 only when output > input and output − input < MAX_FRAME_WORDS. Equal pointers mean the buffer is empty, and this bit is then 0. The output pointer changes only on host writes.
- R5: A frame that reaches the space check while lack of space holds is dropped: frame_drop_o pulses instead of frame_accept_o, the input pointer does not move, and status bit 3 (overflow) becomes 1 on the next edge.
- R6: On frame_done_i, the input offset advances by ceil(frame_len_i / 4) words.
- R7: busy_o and status bit 1 are high from the cycle after an accepted frame start until frame_done_i or a drop.
- R8: Status bits 8, 9 and 10 are the interrupt flags for frame stored, lack of space and overflow. They are enabled by bits 0, 1 and 2 of register 2. A flag sets only while its enable is 1, and the lack-of-space flag sets on every cycle in which the condition holds. Writing 1 to a flag bit in register 1 clears it. irq_o is the OR of the flags.
- R9: Control (register 0) bit 1, while high, clears the overflow status bit and leaves the interrupt flags untouched.
- R10: Control bit 31, while high, returns the sequencer to idle and clears the overflow bit and all interrupt flags. Status bit 31 mirrors it.
- R11: Control bit 0 enables the receiver, and status bit 0 mirrors it. A frame start while disabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register index |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data, combinational on index |
| frame_start_i | input | 1 | Receive path announces a frame |
| frame_done_i | input | 1 | Receive path finished storing the frame |
| frame_len_i | input | 16 | Frame length in bytes, valid with frame_done_i |
| frame_accept_o | output | 1 | Frame may be stored at frame_addr_o |
| frame_drop_o | output | 1 | Frame dropped for lack of space |
| frame_addr_o | output | 32 | Current input address |
| busy_o | output | 1 | Frame in progress |
| mem_req_o | output | 1 | Wrap marker write request |
| mem_addr_o | output | 32 | Wrap marker address |
| mem_data_o | output | 32 | Wrap marker data, always zero |
| mem_ack_i | input | 1 | Memory accepted the marker write |
| irq_o | output | 1 | Any interrupt flag set |

## Verification
Register reads are combinational, so a value that a host write sets can be read at the first falling edge after that write. Flags that follow from a control bit or a pointer change need one more edge, and the bench waits that extra cycle before it reads them. The accept or drop decision appears one cycle after frame_start_i, or one cycle after mem_ack_i when a wrap comes first. The input advance, the stored-frame flag and the overflow bit land on the edge that ends that decision or frame_done_i cycle. Every check samples at the falling edge that follows the edge at which its result is due.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT   = 3'd1;
  localparam logic [REG_AW-1:0] RA_IRQEN  = 3'd2;
  localparam logic [REG_AW-1:0] RA_START  = 3'd3;
  localparam logic [REG_AW-1:0] RA_END    = 3'd4;
  localparam logic [REG_AW-1:0] RA_INPUT  = 3'd5;
  localparam logic [REG_AW-1:0] RA_OUTPUT = 3'd6;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int STAT_EN_BIT   = 0;
  localparam int STAT_BUSY_BIT = 1;
  localparam int STAT_LOS_BIT  = 2;
  localparam int STAT_OVF_BIT  = 3;
  localparam int STAT_IRQ_LSB  = 8;

  localparam int NIRQ    = 3;
  localparam int IRQ_FOK = 0;
  localparam int IRQ_LOS = 1;
  localparam int IRQ_OVF = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRAP  = 2'd1,
    ST_CHECK = 2'd2,
    ST_RECV  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rx_ring_space.sv
module rx_ring_space #(
  parameter int OFF_W           = 18,
  parameter int MAX_FRAME_WORDS = 380
) (
  input  logic [OFF_W-1:0] in_off_i,
  input  logic [OFF_W-1:0] end_off_i,
  input  logic [OFF_W-1:0] out_off_i,
  output logic             need_wrap_o,
  output logic             los_o
);
  localparam int CW = OFF_W + 1;
  localparam logic [CW-1:0] MAXW = CW'(MAX_FRAME_WORDS);

  logic [CW-1:0] to_end, to_out;

  always_comb begin
    to_end = {1'b0, end_off_i} - {1'b0, in_off_i};
    to_out = {1'b0, out_off_i} - {1'b0, in_off_i};
    need_wrap_o = (in_off_i >= end_off_i) || (to_end < MAXW);
    los_o       = (out_off_i > in_off_i) && (to_out < MAXW);
  end
endmodule

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_W = 12,
  parameter int OFF_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [OFF_W-1:0]  in_off_i,
  input  logic              busy_i,
  input  logic              los_i,
  input  logic              ovf_i,
  input  logic [NIRQ-1:0]   irq_i,
  output logic              en_o,
  output logic              clr_ovf_o,
  output logic              srst_o,
  output logic [NIRQ-1:0]   irq_en_o,
  output logic [BASE_W-1:0] base_o,
  output logic [OFF_W-1:0]  start_off_o,
  output logic [OFF_W-1:0]  end_off_o,
  output logic [OFF_W-1:0]  out_off_o,
  output logic              in_wr_o,
  output logic [OFF_W-1:0]  in_wdata_o,
  output logic [NIRQ-1:0]   w1c_o
);
  localparam int SRST_BIT = DATA_W - 1;

  logic              en_q, clr_q, srst_q;
  logic [NIRQ-1:0]   irq_en_q;
  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  start_q, end_q, out_q;
  logic [OFF_W-1:0]  wr_off;

  assign wr_off = reg_wdata_i[OFF_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      clr_q    <= 1'b0;
      srst_q   <= 1'b0;
      irq_en_q <= '0;
      base_q   <= '0;
      start_q  <= '0;
      end_q    <= '0;
      out_q    <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CTRL: begin
          en_q   <= reg_wdata_i[CTRL_EN_BIT];
          clr_q  <= reg_wdata_i[CTRL_CLR_BIT];
          srst_q <= reg_wdata_i[SRST_BIT];
        end
        RA_IRQEN:  irq_en_q <= reg_wdata_i[NIRQ-1:0];
        RA_START: begin
          base_q  <= reg_wdata_i[DATA_W-1 -: BASE_W];
          start_q <= wr_off;
        end
        RA_END:    end_q <= wr_off;
        RA_OUTPUT: out_q <= wr_off;
        default: ;
      endcase
    end
  end

  assign in_wr_o    = reg_we_i && (reg_addr_i == RA_INPUT);
  assign in_wdata_o = wr_off;
  assign w1c_o      = (reg_we_i && (reg_addr_i == RA_STAT)) ?
                      reg_wdata_i[STAT_IRQ_LSB +: NIRQ] : '0;

  function automatic logic [DATA_W-1:0] ptr_word(logic [OFF_W-1:0] off);
    return {base_q, off, 2'b00};
  endfunction

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT]  = en_q;
        reg_rdata_o[CTRL_CLR_BIT] = clr_q;
        reg_rdata_o[SRST_BIT]     = srst_q;
      end
      RA_STAT: begin
        reg_rdata_o[STAT_EN_BIT]            = en_q;
        reg_rdata_o[STAT_BUSY_BIT]          = busy_i;
        reg_rdata_o[STAT_LOS_BIT]           = los_i;
        reg_rdata_o[STAT_OVF_BIT]           = ovf_i;
        reg_rdata_o[STAT_IRQ_LSB +: NIRQ]   = irq_i;
        reg_rdata_o[SRST_BIT]               = srst_q;
      end
      RA_IRQEN:  reg_rdata_o[NIRQ-1:0] = irq_en_q;
      RA_START:  reg_rdata_o = ptr_word(start_q);
      RA_END:    reg_rdata_o = ptr_word(end_q);
      RA_INPUT:  reg_rdata_o = ptr_word(in_off_i);
      RA_OUTPUT: reg_rdata_o = ptr_word(out_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign en_o        = en_q;
  assign clr_ovf_o   = clr_q;
  assign srst_o      = srst_q;
  assign irq_en_o    = irq_en_q;
  assign base_o      = base_q;
  assign start_off_o = start_q;
  assign end_off_o   = end_q;
  assign out_off_o   = out_q;

  // R4: output pointer moves only under host write
  p_out_host_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == RA_OUTPUT) |=> $stable(out_q));
endmodule

// File: rtl/rx_ring_flags.sv
module rx_ring_flags
  import rx_ring_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            srst_i,
  input  logic            clr_ovf_i,
  input  logic            drop_i,
  input  logic            done_i,
  input  logic            los_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NIRQ-1:0] w1c_i,
  output logic            ovf_o,
  output logic [NIRQ-1:0] irq_o
);
  logic            ovf_q;
  logic [NIRQ-1:0] irq_q, set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_FOK] = done_i & irq_en_i[IRQ_FOK];
    set_vec[IRQ_LOS] = los_i  & irq_en_i[IRQ_LOS];
    set_vec[IRQ_OVF] = drop_i & irq_en_i[IRQ_OVF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      irq_q <= '0;
    end else if (srst_i) begin
      ovf_q <= 1'b0;
      irq_q <= '0;
    end else begin
      if (clr_ovf_i)   ovf_q <= 1'b0;
      else if (drop_i) ovf_q <= 1'b1;
      irq_q <= (irq_q & ~w1c_i) | set_vec;
    end
  end

  assign ovf_o = ovf_q;
  assign irq_o = irq_q;

  p_irq_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_q & ~$past(irq_q) & ~$past(irq_en_i)) == '0));
  p_ovf_from_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(drop_i));
  p_clr_ovf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ovf_i |=> !ovf_q);
  p_srst_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (irq_q == '0) && !ovf_q);
endmodule

// File: rtl/rx_ring_seq.sv
module rx_ring_seq
  import rx_ring_pkg::*;
#(
  parameter int BASE_W = 12,
  parameter int OFF_W  = 18,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              en_i,
  input  logic              frame_start_i,
  input  logic              frame_done_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              need_wrap_i,
  input  logic              los_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic              in_wr_i,
  input  logic [OFF_W-1:0]  in_wdata_i,
  input  logic              mem_ack_i,
  output logic [OFF_W-1:0]  in_off_o,
  output logic              busy_o,
  output logic              accept_o,
  output logic              drop_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [BASE_W+OFF_W+1:0] in_addr_o
);
  localparam int WORDS_W = LEN_W - 1;

  seq_state_e         state_q, state_d;
  logic [OFF_W-1:0]   in_off_q;
  logic [LEN_W:0]     len_rnd;
  logic [WORDS_W-1:0] words;

  assign len_rnd = {1'b0, frame_len_i} + (LEN_W+1)'(3);
  assign words   = len_rnd[LEN_W:2];

  always_comb begin
    state_d   = state_q;
    accept_o  = 1'b0;
    drop_o    = 1'b0;
    done_o    = 1'b0;
    mem_req_o = 1'b0;
    case (state_q)
      ST_IDLE:
        if (frame_start_i && en_i) state_d = need_wrap_i ? ST_WRAP : ST_CHECK;
      ST_WRAP: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) state_d = ST_CHECK;
      end
      ST_CHECK:
        if (los_i) begin
          drop_o  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          accept_o = 1'b1;
          state_d  = ST_RECV;
        end
      ST_RECV:
        if (frame_done_i) begin
          done_o  = 1'b1;
          state_d = ST_IDLE;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else if (srst_i) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  // hardware updates win over a host write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_off_q <= '0;
    else if (!srst_i && state_q == ST_WRAP && mem_ack_i) in_off_q <= start_off_i;
    else if (!srst_i && done_o) in_off_q <= in_off_q + OFF_W'(words);
    else if (in_wr_i) in_off_q <= in_wdata_i;
  end

  assign in_off_o  = in_off_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign in_addr_o = {base_i, in_off_q, 2'b00};

  p_accept_not_los_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !los_i);
  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && drop_o));
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !srst_i) |=> mem_req_o);
  p_wrap_to_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !srst_i) |=> (in_off_q == $past(start_off_i)));
  p_busy_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(frame_start_i && en_i));
endmodule

// File: rtl/rx_ring_ptr_mgr.sv
module rx_ring_ptr_mgr
  import rx_ring_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int BASE_W          = 12,
  parameter int LEN_W           = 16,
  parameter int MAX_FRAME_WORDS = 380
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_start_i,
  input  logic              frame_done_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  output logic              frame_accept_o,
  output logic              frame_drop_o,
  output logic [DATA_W-1:0] frame_addr_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ack_i,
  output logic              irq_o
);
  localparam int OFF_W = DATA_W - BASE_W - 2;

  logic              en, clr_ovf, srst, in_wr, need_wrap, los, ovf, done;
  logic [NIRQ-1:0]   irq_en, irq, w1c;
  logic [BASE_W-1:0] base;
  logic [OFF_W-1:0]  start_off, end_off, out_off, in_off, in_wdata;
  logic [DATA_W-1:0] in_addr;

  rx_ring_regs #(.DATA_W(DATA_W), .BASE_W(BASE_W), .OFF_W(OFF_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .in_off_i(in_off), .busy_i(busy_o), .los_i(los), .ovf_i(ovf), .irq_i(irq),
    .en_o(en), .clr_ovf_o(clr_ovf), .srst_o(srst), .irq_en_o(irq_en),
    .base_o(base), .start_off_o(start_off), .end_off_o(end_off),
    .out_off_o(out_off), .in_wr_o(in_wr), .in_wdata_o(in_wdata), .w1c_o(w1c)
  );

  rx_ring_space #(.OFF_W(OFF_W), .MAX_FRAME_WORDS(MAX_FRAME_WORDS)) u_space (
    .in_off_i(in_off), .end_off_i(end_off), .out_off_i(out_off),
    .need_wrap_o(need_wrap), .los_o(los)
  );

  rx_ring_seq #(.BASE_W(BASE_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .srst_i(srst), .en_i(en),
    .frame_start_i, .frame_done_i, .frame_len_i,
    .need_wrap_i(need_wrap), .los_i(los), .base_i(base),
    .start_off_i(start_off), .in_wr_i(in_wr), .in_wdata_i(in_wdata),
    .mem_ack_i, .in_off_o(in_off), .busy_o, .accept_o(frame_accept_o),
    .drop_o(frame_drop_o), .done_o(done), .mem_req_o, .in_addr_o(in_addr)
  );

  rx_ring_flags u_flags (
    .clk_i, .rst_ni, .srst_i(srst), .clr_ovf_i(clr_ovf),
    .drop_i(frame_drop_o), .done_i(done), .los_i(los),
    .irq_en_i(irq_en), .w1c_i(w1c), .ovf_o(ovf), .irq_o(irq)
  );

  assign frame_addr_o = in_addr;
  assign mem_addr_o   = in_addr;
  assign mem_data_o   = '0;
  assign irq_o        = |irq;
endmodule

// File: tb/rx_ring_ptr_mgr_tb_top.sv
module rx_ring_ptr_mgr_tb_top;
  localparam int CLK_P = 10;
  localparam int MAXW  = 380;
  localparam logic [11:0] BASE = 12'hABC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0, frame_done = 1'b0;
  logic [15:0] frame_len = '0;
  logic        accept, drop, busy, mem_req, irq, mem_ack = 1'b0;
  logic [31:0] frame_addr, mem_addr, mem_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_ptr_mgr #(.MAX_FRAME_WORDS(MAXW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .frame_start_i(frame_start), .frame_done_i(frame_done), .frame_len_i(frame_len),
    .frame_accept_o(accept), .frame_drop_o(drop), .frame_addr_o(frame_addr),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .mem_ack_i(mem_ack), .irq_o(irq)
  );

  function automatic logic [31:0] ptr(int off);
    return {BASE, 18'(off), 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(string req, logic [2:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    #1;
  endtask

  task automatic end_frame(int len);
    @(negedge clk);
    frame_done = 1'b1; frame_len = 16'(len);
    @(negedge clk);
    frame_done = 1'b0;
    #1;
  endtask

  task automatic set_ptrs(int in_off, int out_off);
    reg_wr(3'd5, ptr(in_off));
    reg_wr(3'd6, ptr(out_off));
  endtask

  task automatic t_reset();
    for (int a = 0; a < 7; a++) reg_chk("R1 reset value", 3'(a), 32'h0);
    chk("R7 reset busy", {31'b0, busy}, 32'h0);
    chk("R8 reset irq", {31'b0, irq}, 32'h0);
    chk("R2 reset mem_req", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_addr_fields();
    reg_wr(3'd3, {BASE, 18'd256, 2'b11});
    reg_chk("R1 start readback", 3'd3, ptr(256));
    reg_wr(3'd4, {12'hFFF, 18'd1256, 2'b01});
    reg_chk("R1 end base copy", 3'd4, ptr(1256));
    reg_wr(3'd5, {12'h123, 18'd256, 2'b10});
    reg_chk("R1 input base copy", 3'd5, ptr(256));
    reg_wr(3'd6, {12'h123, 18'd256, 2'b10});
    reg_chk("R1 output base copy", 3'd6, ptr(256));
  endtask

  task automatic t_enable();
    start_frame();
    chk("R11 start ignored when disabled busy", {31'b0, busy}, 32'h0);
    chk("R11 start ignored when disabled accept", {31'b0, accept}, 32'h0);
    reg_wr(3'd0, 32'h1);
    reg_chk("R11 enable mirrored", 3'd1, 32'h1);
  endtask

  task automatic t_normal();
    reg_wr(3'd2, 32'h1);
    start_frame();
    chk("R3 accept", {31'b0, accept}, 32'h1);
    chk("R3 frame addr", frame_addr, ptr(256));
    chk("R3 no mem req", {31'b0, mem_req}, 32'h0);
    chk("R7 busy on accept", {31'b0, busy}, 32'h1);
    idle(1);
    chk("R7 busy while receiving", {31'b0, busy}, 32'h1);
    chk("R3 accept is a pulse", {31'b0, accept}, 32'h0);
    end_frame(101);
    chk("R7 busy cleared", {31'b0, busy}, 32'h0);
    reg_chk("R6 advance rounded up", 3'd5, ptr(282));
    reg_chk("R8 frame irq set", 3'd1, 32'h101);
    chk("R8 irq pin", {31'b0, irq}, 32'h1);
    reg_chk("R4 output untouched by hw", 3'd6, ptr(256));
    reg_wr(3'd1, 32'h100);
    reg_chk("R8 write one clears", 3'd1, 32'h1);
    chk("R8 irq pin cleared", {31'b0, irq}, 32'h0);
    reg_wr(3'd2, 32'h0);
    start_frame();
    end_frame(400);
    reg_chk("R6 advance exact words", 3'd5, ptr(382));
    reg_chk("R8 no flag when disabled", 3'd1, 32'h1);
  endtask

  task automatic t_wrap();
    set_ptrs(900, 900);
    start_frame();
    chk("R2 wrap request", {31'b0, mem_req}, 32'h1);
    chk("R2 marker addr", mem_addr, ptr(900));
    chk("R2 marker data", mem_data, 32'h0);
    chk("R2 no accept before marker", {31'b0, accept}, 32'h0);
    idle(1);
    chk("R2 request held", {31'b0, mem_req}, 32'h1);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    #1;
    chk("R2 request released", {31'b0, mem_req}, 32'h0);
    chk("R2 accept after wrap", {31'b0, accept}, 32'h1);
    chk("R2 addr after wrap", frame_addr, ptr(256));
    end_frame(4);
    reg_chk("R6 advance after wrap", 3'd5, ptr(257));
  endtask

  task automatic t_boundary();
    set_ptrs(1256 - MAXW, 1256 - MAXW);
    start_frame();
    chk("R3 exact fit no wrap", {31'b0, mem_req}, 32'h0);
    chk("R3 exact fit accept", frame_addr, ptr(1256 - MAXW));
    end_frame(8);
    set_ptrs(1256 - MAXW + 1, 1256 - MAXW + 1);
    start_frame();
    chk("R2 one short wraps", {31'b0, mem_req}, 32'h1);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    #1;
    chk("R2 wrap accept addr", frame_addr, ptr(256));
    end_frame(4);
  endtask

  task automatic t_los();
    set_ptrs(256, 256 + MAXW - 1);
    reg_chk("R4 gap below max", 3'd1, 32'h5);
    reg_wr(3'd6, ptr(256 + MAXW));
    reg_chk("R4 gap equal max", 3'd1, 32'h1);
    reg_wr(3'd6, ptr(256));
    reg_chk("R4 empty buffer", 3'd1, 32'h1);
    reg_wr(3'd6, ptr(100));
    reg_chk("R4 output below input", 3'd1, 32'h1);
  endtask

  task automatic t_drop_and_clear();
    reg_wr(3'd2, 32'h6);
    reg_wr(3'd6, ptr(400));
    idle(1);
    reg_chk("R8 lack of space flag", 3'd1, 32'h205);
    start_frame();
    chk("R5 drop pulse", {31'b0, drop}, 32'h1);
    chk("R5 no accept", {31'b0, accept}, 32'h0);
    idle(1);
    reg_chk("R5 overflow set", 3'd1, 32'h60D);
    reg_chk("R5 input unchanged", 3'd5, ptr(256));
    chk("R7 busy ends on drop", {31'b0, busy}, 32'h0);
    reg_wr(3'd0, 32'h3);
    idle(1);
    reg_chk("R9 overflow cleared flags kept", 3'd1, 32'h605);
    reg_wr(3'd0, 32'h1);
    reg_wr(3'd6, ptr(256));
    idle(1);
    reg_wr(3'd1, 32'h600);
    reg_chk("R8 flags cleared", 3'd1, 32'h1);
  endtask

  task automatic t_soft_reset();
    reg_wr(3'd2, 32'h4);
    reg_wr(3'd6, ptr(400));
    start_frame();
    reg_wr(3'd6, ptr(256));
    start_frame();
    chk("R10 setup accept", {31'b0, accept}, 32'h1);
    reg_wr(3'd0, 32'h8000_0001);
    idle(1);
    reg_chk("R10 reset clears and mirrors", 3'd1, 32'h8000_0001);
    chk("R10 busy cleared", {31'b0, busy}, 32'h0);
    chk("R10 irq pin cleared", {31'b0, irq}, 32'h0);
    reg_wr(3'd0, 32'h1);
    reg_chk("R10 released", 3'd1, 32'h1);
    start_frame();
    chk("R10 accept after release", frame_addr, ptr(256));
    end_frame(4);
    reg_chk("R6 advance after release", 3'd5, ptr(257));
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_addr_fields();
    t_enable();
    t_normal();
    t_wrap();
    t_boundary();
    t_los();
    t_drop_and_clear();
    t_soft_reset();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule